// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block is the address and strobe logic for an 8-bit bus with a 16-bit address space, a bus-phase enable (E) and a single read/write line. It sorts every CPU address into one of several regions. The lower 32 KB is a swappable window into a 512 KB RAM. The upper 32 KB holds a fixed RAM page, a 4 KB boot ROM window at the very top, and a 4 KB I/O window whose position is chosen by jumpers. From that region it drives active-low chip selects, the memory read and write strobes, and the extended physical address bits for the RAM and the ROM.

Address decoding is purely combinational from the address, the jumpers and the overlay input. E enters only at the final strobe stage. A CPU-writable 8-bit page register holds a 4-bit RAM page, a 3-bit ROM bank and a status LED bit. A small phase state machine follows E and grants at most one register load per E-high phase. The load happens only on a write cycle to the register's own slot.

The state machine has three states. PH_IDLE means E is low. On a rising E it takes the transition LOAD (to PH_DONE) when the cycle is a write to the register slot, or the transition PASS (to PH_OPEN) otherwise. Both PH_OPEN and PH_DONE take the transition CLOSE back to PH_IDLE once E is low. Reset forces PH_IDLE.

Top module: `bank_decoder`

## Requirements
- R1: With A15 = 0 and no overlay, the RAM select is low and ram_addr = {page[3:0], A[14:0]}. In 128 KB mode, bit 17 of that value is inverted.
- R2: A15 = 1 with A[14:12] neither 7 nor the active I/O segment selects RAM at fixed physical page 15: ram_addr[18:15] = 4'b1111, with bit 17 inverted in 128 KB mode.
- R3: A[15:12] = 4'hF selects the ROM, and rom_addr = {page[6:4] | boot_jmp, A[11:0]}.
- R4: The I/O window is the 4 KB segment with A15 = 1 and A[14:12] = io_sel. An io_sel value of 7 acts as 6. Inside the window, A[11:10] chooses the region: 0 is the serial chip, 1 is the page register, 2 is external region 0 and 3 is external region 1. At most one chip select is low at any time.
- R5: mem_rd_n is low exactly when E = 1, rw = 1 and a RAM or ROM select is active. mem_wr_n is low exactly when E = 1, rw = 0 and a RAM or ROM select is active.
- R6: While dis = 1, the RAM and ROM selects and both memory strobes stay high. The I/O selects are unaffected.
- R7: The page register loads d_in at the first clock edge of an E-high phase, and only when that cycle is a write (rw = 0) to the register slot. A read of the slot, a write that arrives later in the same E-high phase, or any cycle with E low leaves the register unchanged.
- R8: After an active-low reset, the page register is 0 and the phase machine is in PH_IDLE.
- R9: The led output equals page register bit 7.
- R10: In 128 KB mode (small_ram = 1), only ram_addr bit 17 differs from 512 KB mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the phase machine and the page register |
| rst_n | input | 1 | Active-low reset |
| addr | input | 16 | CPU address |
| d_in | input | 8 | CPU write data for the page register |
| e | input | 1 | Bus-phase enable |
| rw | input | 1 | 1 for a read, 0 for a write |
| dis | input | 1 | Overlay: suppresses on-board memory |
| io_sel | input | 3 | Jumper selecting the I/O segment (6 gives $E000) |
| boot_jmp | input | 3 | Jumper bits ORed into the ROM bank |
| small_ram | input | 1 | 1 when a 128 KB RAM is fitted |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| ser_cs_n | output | 1 | Serial chip select, active low |
| ext0_cs_n | output | 1 | External region 0 select, active low |
| ext1_cs_n | output | 1 | External region 1 select, active low |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| ram_addr | output | 19 | Physical RAM address |
| rom_addr | output | 15 | Physical ROM address |
| led | output | 1 | Status LED control |

## Verification
Some properties are checked on every cycle. The strobes never go low without E and the matching rw level, and never both at once. The overlay keeps the memory selects high. At most one select is low. The low address bits pass through to both memories. The LED bit cannot change across an edge where E was low or rw was high.

The exact page and bank values need the bench's scenarios, because they depend on what was loaded earlier. These scenarios cover the refused second load within one E-high phase, the OR with the boot jumpers, the clamping of the I/O jumper and the bit inversion in 128 KB mode.

// File: rtl/bdec_pkg.sv
package bdec_pkg;

    typedef enum logic [2:0] {
        RG_RAM_LO,
        RG_RAM_HI,
        RG_ROM,
        RG_SER,
        RG_PAGE,
        RG_EXT0,
        RG_EXT1
    } region_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_OPEN,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/bdec_region.sv
module bdec_region
    import bdec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEG_W  = 3
) (
    input  logic [SEG_W+2:0] hi_addr,
    input  logic [SEG_W-1:0] io_sel,
    output region_e          region
);
    localparam int SUB_W = 2;
    localparam logic [SEG_W-1:0] TOP_SEG = {SEG_W{1'b1}};
    localparam int UNUSED_CHK = ADDR_W;

    logic [SEG_W-1:0] seg;
    logic [SUB_W-1:0] sub;
    logic [SEG_W-1:0] io_eff;

    assign seg    = hi_addr[SEG_W+1 -: SEG_W];
    assign sub    = hi_addr[SUB_W-1:0];
    assign io_eff = (io_sel == TOP_SEG) ? TOP_SEG - 1'b1 : io_sel;

    always_comb begin
        region = RG_RAM_HI;
        if (!hi_addr[SEG_W+2]) begin
            region = RG_RAM_LO;
        end else if (seg == TOP_SEG) begin
            region = RG_ROM;
        end else if (seg == io_eff) begin
            unique case (sub)
                2'd0:    region = RG_SER;
                2'd1:    region = RG_PAGE;
                2'd2:    region = RG_EXT0;
                default: region = RG_EXT1;
            endcase
        end
    end
endmodule

// File: rtl/bdec_page_fsm.sv
module bdec_page_fsm
    import bdec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e,
    input  logic              rw,
    input  logic              hit,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] page
);
    phase_e state_q, state_d;
    logic   load;
    logic   load_ok;

    assign load_ok = e && hit && !rw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (e) state_d = load_ok ? PH_DONE : PH_OPEN;
            end
            PH_OPEN, PH_DONE: begin
                if (!e) state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        load = 1'b0;
        unique case (state_q)
            PH_IDLE: load = load_ok;
            default: load = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    page <= '0;
        else if (load) page <= d_in;
    end
endmodule

// File: rtl/bdec_map.sv
module bdec_map
    import bdec_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int RAM_PAGE_W  = 4,
    parameter int ROM_BANK_W  = 3,
    parameter int SEG_W       = 3,
    parameter int UPPER_PAGE  = 15,
    parameter int PHYS_W      = RAM_PAGE_W + ADDR_W - 1,
    parameter int ROM_AW      = ROM_BANK_W + ADDR_W - 1 - SEG_W,
    parameter int SMALL_BIT   = PHYS_W - 2
) (
    input  region_e               region,
    input  logic [ADDR_W-2:0]     lo_addr,
    input  logic [RAM_PAGE_W-1:0] ram_page,
    input  logic [ROM_BANK_W-1:0] rom_bank,
    input  logic [ROM_BANK_W-1:0] boot_jmp,
    input  logic                  e,
    input  logic                  rw,
    input  logic                  dis,
    input  logic                  small_ram,
    output logic                  ram_cs_n,
    output logic                  rom_cs_n,
    output logic                  ser_cs_n,
    output logic                  ext0_cs_n,
    output logic                  ext1_cs_n,
    output logic                  mem_rd_n,
    output logic                  mem_wr_n,
    output logic [PHYS_W-1:0]     ram_addr,
    output logic [ROM_AW-1:0]     rom_addr
);
    localparam int OFF_W = ADDR_W - 1 - SEG_W;
    localparam logic [RAM_PAGE_W-1:0] FIXED_PG = RAM_PAGE_W'(UPPER_PAGE);

    logic ram_hit, rom_hit, ser_hit, ext0_hit, ext1_hit;
    logic mem_sel;
    logic [RAM_PAGE_W-1:0] pg_sel;
    logic [PHYS_W-1:0]     raw_addr;

    always_comb begin
        ram_hit  = 1'b0;
        rom_hit  = 1'b0;
        ser_hit  = 1'b0;
        ext0_hit = 1'b0;
        ext1_hit = 1'b0;
        unique case (region)
            RG_RAM_LO, RG_RAM_HI: ram_hit  = 1'b1;
            RG_ROM:               rom_hit  = 1'b1;
            RG_SER:               ser_hit  = 1'b1;
            RG_EXT0:              ext0_hit = 1'b1;
            RG_EXT1:              ext1_hit = 1'b1;
            default:              ;
        endcase
    end

    assign ram_cs_n  = !(ram_hit && !dis);
    assign rom_cs_n  = !(rom_hit && !dis);
    assign ser_cs_n  = !ser_hit;
    assign ext0_cs_n = !ext0_hit;
    assign ext1_cs_n = !ext1_hit;

    assign mem_sel  = (ram_hit || rom_hit) && !dis;
    assign mem_rd_n = !(e && rw && mem_sel);
    assign mem_wr_n = !(e && !rw && mem_sel);

    assign pg_sel   = (region == RG_RAM_LO) ? ram_page : FIXED_PG;
    assign raw_addr = {pg_sel, lo_addr};

    for (genvar b = 0; b < PHYS_W; b++) begin : g_bit
        if (b == SMALL_BIT) begin : g_flip
            assign ram_addr[b] = raw_addr[b] ^ small_ram;
        end else begin : g_pass
            assign ram_addr[b] = raw_addr[b];
        end
    end

    assign rom_addr = {rom_bank | boot_jmp, lo_addr[OFF_W-1:0]};
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
    import bdec_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int RAM_PAGE_W = 4,
    parameter int ROM_BANK_W = 3,
    parameter int SEG_W      = 3,
    parameter int UPPER_PAGE = 15,
    parameter int DATA_W     = RAM_PAGE_W + ROM_BANK_W + 1,
    parameter int PHYS_W     = RAM_PAGE_W + ADDR_W - 1,
    parameter int ROM_AW     = ROM_BANK_W + ADDR_W - 1 - SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d_in,
    input  logic              e,
    input  logic              rw,
    input  logic              dis,
    input  logic [SEG_W-1:0]  io_sel,
    input  logic [ROM_BANK_W-1:0] boot_jmp,
    input  logic              small_ram,
    output logic              ram_cs_n,
    output logic              rom_cs_n,
    output logic              ser_cs_n,
    output logic              ext0_cs_n,
    output logic              ext1_cs_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [PHYS_W-1:0] ram_addr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              led
);
    localparam int HI_LSB = ADDR_W - 1 - SEG_W - 2;

    region_e           region;
    logic [DATA_W-1:0] page;

    bdec_region #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_region (
        .hi_addr (addr[ADDR_W-1:HI_LSB]),
        .io_sel  (io_sel),
        .region  (region)
    );

    bdec_page_fsm #(.DATA_W(DATA_W)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .e     (e),
        .rw    (rw),
        .hit   (region == RG_PAGE),
        .d_in  (d_in),
        .page  (page)
    );

    bdec_map #(
        .ADDR_W(ADDR_W), .RAM_PAGE_W(RAM_PAGE_W), .ROM_BANK_W(ROM_BANK_W),
        .SEG_W(SEG_W), .UPPER_PAGE(UPPER_PAGE), .PHYS_W(PHYS_W), .ROM_AW(ROM_AW)
    ) u_map (
        .region    (region),
        .lo_addr   (addr[ADDR_W-2:0]),
        .ram_page  (page[RAM_PAGE_W-1:0]),
        .rom_bank  (page[RAM_PAGE_W +: ROM_BANK_W]),
        .boot_jmp  (boot_jmp),
        .e         (e),
        .rw        (rw),
        .dis       (dis),
        .small_ram (small_ram),
        .ram_cs_n  (ram_cs_n),
        .rom_cs_n  (rom_cs_n),
        .ser_cs_n  (ser_cs_n),
        .ext0_cs_n (ext0_cs_n),
        .ext1_cs_n (ext1_cs_n),
        .mem_rd_n  (mem_rd_n),
        .mem_wr_n  (mem_wr_n),
        .ram_addr  (ram_addr),
        .rom_addr  (rom_addr)
    );

    assign led = page[DATA_W-1];
endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk #(
    parameter int ADDR_W = 16,
    parameter int SEG_W  = 3,
    parameter int PHYS_W = 19,
    parameter int ROM_AW = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              e,
    input logic              rw,
    input logic              dis,
    input logic [SEG_W-1:0]  io_sel,
    input logic              ram_cs_n,
    input logic              rom_cs_n,
    input logic              ser_cs_n,
    input logic              ext0_cs_n,
    input logic              ext1_cs_n,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic [PHYS_W-1:0] ram_addr,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              led
);
    localparam int OFF_W = ADDR_W - 1 - SEG_W;
    localparam logic [SEG_W-1:0] TOP = {SEG_W{1'b1}};

    logic [SEG_W-1:0] seg, io_eff;
    assign seg    = addr[ADDR_W-2 -: SEG_W];
    assign io_eff = (io_sel == TOP) ? TOP - 1'b1 : io_sel;

    a_r5_rd_needs_e: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (e && rw && (!ram_cs_n || !rom_cs_n)));
    a_r5_wr_needs_e: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (e && !rw && (!ram_cs_n || !rom_cs_n)));
    a_r5_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_n || mem_wr_n);
    a_r6_overlay: assert property (@(posedge clk) disable iff (!rst_n)
        dis |-> (ram_cs_n && rom_cs_n && mem_rd_n && mem_wr_n));
    a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!ram_cs_n, !rom_cs_n, !ser_cs_n, !ext0_cs_n, !ext1_cs_n}));
    a_r1_low_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr[ADDR_W-1] && !dis) |-> (!ram_cs_n && ram_addr[ADDR_W-2:0] == addr[ADDR_W-2:0]));
    a_r2_upper_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1] && seg != TOP && seg != io_eff && !dis) |-> !ram_cs_n);
    a_r3_rom_offset: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cs_n |-> (rom_addr[OFF_W-1:0] == addr[OFF_W-1:0] && seg == TOP));
    a_r7_no_load_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rw || !e) |=> $stable(led));
endmodule

bind bank_decoder bank_decoder_chk #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .PHYS_W(PHYS_W), .ROM_AW(ROM_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .e(e), .rw(rw), .dis(dis),
    .io_sel(io_sel), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n),
    .ser_cs_n(ser_cs_n), .ext0_cs_n(ext0_cs_n), .ext1_cs_n(ext1_cs_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .ram_addr(ram_addr),
    .rom_addr(rom_addr), .led(led)
);

// File: tb/test_bank_decoder.sv
module test_bank_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  d_in = '0;
    logic        e = 1'b0, rw = 1'b1, dis = 1'b0, small_ram = 1'b0;
    logic [2:0]  io_sel = 3'd6, boot_jmp = 3'd0;
    logic        ram_cs_n, rom_cs_n, ser_cs_n, ext0_cs_n, ext1_cs_n;
    logic        mem_rd_n, mem_wr_n, led;
    logic [18:0] ram_addr;
    logic [14:0] rom_addr;

    int checks = 0, fails = 0;
    logic [7:0] mdl_page = '0;
    bit done = 0;

    always #2 clk = ~clk;

    bank_decoder i_bank_decoder (.*);

    // region codes: 0 low RAM, 1 upper RAM, 2 ROM, 3 serial, 4 page reg, 5 ext0, 6 ext1
    function automatic int exp_region(input logic [15:0] a, input logic [2:0] io);
        logic [2:0] ie = (io == 3'd7) ? 3'd6 : io;
        if (!a[15]) return 0;
        if (a[14:12] == 3'd7) return 2;
        if (a[14:12] == ie) return 3 + int'(a[11:10]) + ((a[11:10] >= 2'd1) ? 0 : 0);
        return 1;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int r = exp_region(addr, io_sel);
        logic ram_s = (r <= 1) && !dis;
        logic rom_s = (r == 2) && !dis;
        logic [18:0] ra;
        check(req, "ram_cs_n", ram_cs_n, !ram_s);
        check(req, "rom_cs_n", rom_cs_n, !rom_s);
        check("R4", "ser_cs_n", ser_cs_n, !(r == 3));
        check("R4", "ext0_cs_n", ext0_cs_n, !(r == 5));
        check("R4", "ext1_cs_n", ext1_cs_n, !(r == 6));
        check("R5", "mem_rd_n", mem_rd_n, !(e && rw && (ram_s || rom_s)));
        check("R5", "mem_wr_n", mem_wr_n, !(e && !rw && (ram_s || rom_s)));
        check("R9", "led", led, mdl_page[7]);
        if (ram_s) begin
            ra = {(r == 0) ? mdl_page[3:0] : 4'hF, addr[14:0]};
            if (small_ram) ra[17] = ~ra[17];
            check(r == 0 ? "R1" : "R2", "ram_addr", ram_addr, ra);
        end
        if (rom_s) check("R3", "rom_addr", rom_addr, {mdl_page[6:4] | boot_jmp, addr[11:0]});
    endtask

    // one bus cycle starting from E low (phase machine idle)
    task automatic cycle(input string req, input logic [15:0] a, input logic [7:0] d,
                         input logic ee, input logic w_r, input logic ds,
                         input logic [2:0] io, input logic [2:0] jm, input logic sm);
        @(negedge clk);
        addr = a; d_in = d; e = ee; rw = w_r; dis = ds; io_sel = io; boot_jmp = jm; small_ram = sm;
        @(posedge clk); #1;
        if (ee && !w_r && exp_region(a, io) == 4) mdl_page = d;  // R7 load
        check_all(req);
        @(negedge clk); e = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        check("R8", "led", led, 1'b0);
        check("R8", "ram_addr page", ram_addr[18:15], 4'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R7 load to page register at $E400
        cycle("R7", 16'hE400, 8'hA5, 1, 0, 0, 3'd6, 3'd0, 0);
        cycle("R1", 16'h1234, 8'h00, 1, 1, 0, 3'd6, 3'd0, 0);
        cycle("R3", 16'hF123, 8'h00, 1, 1, 0, 3'd6, 3'd0, 0);
        // R7 read of the slot leaves page alone
        cycle("R7", 16'hE7FF, 8'h3C, 1, 1, 0, 3'd6, 3'd0, 0);
        cycle("R7", 16'h0042, 8'h00, 1, 1, 0, 3'd6, 3'd0, 0);
        // R7 second load in same E-high phase refused
        @(negedge clk); addr = 16'hE400; d_in = 8'h12; e = 1; rw = 0;
        @(posedge clk); #1; mdl_page = 8'h12;
        @(negedge clk); d_in = 8'h9F;
        @(posedge clk); #1;
        check("R7", "led after refused load", led, 1'b0);
        check_all("R7");
        @(negedge clk); e = 0; rw = 1;
        @(posedge clk); #1;
        // R7 write arriving late in an E-high phase refused
        @(negedge clk); addr = 16'h2000; e = 1; rw = 1;
        @(posedge clk); #1;
        @(negedge clk); addr = 16'hE400; d_in = 8'hFF; rw = 0;
        @(posedge clk); #1;
        check("R7", "led after late write", led, 1'b0);
        @(negedge clk); e = 0; rw = 1;
        @(posedge clk); #1;
        // R4 jumper value 7 acts as 6; R3 OR with boot jumper
        cycle("R4", 16'hE000, 8'h00, 0, 1, 0, 3'd7, 3'd0, 0);
        cycle("R3", 16'hFABC, 8'h00, 1, 1, 0, 3'd6, 3'd5, 0);
        // R4 relocated window, ext regions
        cycle("R4", 16'h8800, 8'h00, 0, 1, 0, 3'd0, 3'd0, 0);
        cycle("R4", 16'h8C00, 8'h00, 0, 1, 0, 3'd0, 3'd0, 0);
        cycle("R2", 16'hE000, 8'h00, 1, 0, 0, 3'd0, 3'd0, 0);
        // R6 overlay, R10 small RAM
        cycle("R6", 16'h0100, 8'h00, 1, 0, 1, 3'd6, 3'd0, 0);
        cycle("R10", 16'h3000, 8'h00, 1, 1, 0, 3'd6, 3'd0, 1);
        cycle("R10", 16'hC000, 8'h00, 1, 0, 0, 3'd6, 3'd0, 1);
        // load with LED bit set: R9
        cycle("R9", 16'hE400, 8'hFB, 1, 0, 0, 3'd6, 3'd0, 0);
        cycle("R10", 16'h7FFF, 8'h00, 1, 1, 0, 3'd6, 3'd0, 1);

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a = 16'($urandom);
            if (($urandom % 8) == 0) a = {4'hE, 2'b01, a[9:0]};
            cycle("R5", a, 8'($urandom), 1'($urandom), 1'($urandom), (($urandom % 6) == 0),
                  (($urandom % 3) == 0) ? 3'($urandom) : 3'd6, 3'($urandom), 1'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule